// File: doc/BRIEF.md
# Program Counter Sequencer with One-Entry Return Stack

This block holds the fetch address of a small 4-bit controller and chooses the next address once per executed instruction. It handles straight-line advance, unconditional and conditional branches, calls, the two kinds of return, the two interrupt vectors, reset, and the entry into and exit from the halted state. A single return entry holds the resume address. When the entry is written by an interrupt it also holds the carry flag.

Decode and condition evaluation sit outside the block. Each cycle the surrounding core presents:
- a step strobe, together with the instruction's length and its kind;
- the address field of the instruction;
- the already-evaluated branch condition;
- the interrupt-take strobes, the wake strobe, the interrupt-enable state and the live carry.

The block returns:
- the program counter;
- a carry value and a strobe that tells the core when to load that carry back;
- the page nibble that a table lookup uses.

Top module: `pc_seq`

## Requirements
- R1: While `rst_n` is low, `pc` is 000H and `halted` is 0.
- R2: An executed step of kind 0 (sequential) adds 1 to `pc` when `len2`=0 and adds 2 when `len2`=1. The result wraps modulo 4096.
- R3: An executed step of kind 1 (jump) loads all 12 bits of `target` into `pc`.
- R4: An executed step of kind 3 (conditional) with `cond_true`=1 sets `pc` bits 10:0 to `target` bits 10:0 and keeps `pc` bit 11. With `cond_true`=0 it adds 2 to `pc`.
- R5: An executed step of kind 2 (call) loads `target` and stores `pc`+2 as the return address. A later step of kind 4 (return) loads that stored address, and `carry_restore_v` stays 0.
- R6: When not halted, `take_ext`=1 loads 008H and `take_tmr`=1 alone loads 004H. Each stores the current `pc` and `carry_in`. If `take_ext` and `take_tmr` are both 1, 008H wins. An interrupt cycle suppresses any `step` in that cycle.
- R7: An executed step of kind 5 (interrupt return) loads the stored address. In that same cycle it drives `carry_restore_v`=1 with `carry_restore` equal to the carry stored by the last interrupt.
- R8: A second store overwrites the single entry. A call made inside an interrupt routine therefore makes the next return go to the call's address plus 2.
- R9: An executed step of kind 6 (halt) adds 2 to `pc` and sets `halted`. While halted, `pc` holds, and `step`, `take_tmr` and `take_ext` have no effect.
- R10: While halted, `wake`=1 clears `halted`. If `int_en`=1, `wake` also loads 008H and stores the address after the halt. If `int_en`=0, `pc` stays at the address after the halt.
- R11: `tbl_page` equals `pc` bits 11:8 when `page_f`=0 and equals 1111 when `page_f`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step | input | 1 | An instruction completes this cycle |
| len2 | input | 1 | Completing instruction is 2 bytes long |
| kind | input | 3 | Control kind: 0 seq, 1 jump, 2 call, 3 cond, 4 ret, 5 iret, 6 halt |
| target | input | 12 | Address field of the instruction |
| cond_true | input | 1 | Evaluated branch condition |
| take_tmr | input | 1 | Timer interrupt accepted |
| take_ext | input | 1 | External interrupt accepted |
| wake | input | 1 | Wake event while halted |
| int_en | input | 1 | Interrupts currently enabled |
| carry_in | input | 1 | Live carry flag |
| page_f | input | 1 | Table lookup uses the fixed top page |
| pc | output | 12 | Program counter |
| halted | output | 1 | Halted state |
| carry_restore | output | 1 | Carry value to restore |
| carry_restore_v | output | 1 | Load `carry_restore` into the carry flag |
| tbl_page | output | 4 | Page nibble for table lookups |

## Verification
The bench uses the default parameters: a 12-bit counter with vectors at 004H and 008H. This places bit 11 within reach, so a conditional branch taken from the upper half of the space shows that bit 11 is kept. A sequential step at FFEH shows the wrap to zero. The default vectors let both interrupt kinds and both wake-up paths be compared against the behavioural model on every clock.

// File: rtl/pc_seq.sv
module pc_seq #(
  parameter int AW = 12,
  parameter int PW = 4,
  parameter logic [AW-1:0] VEC_TMR = 12'h004,
  parameter logic [AW-1:0] VEC_EXT = 12'h008
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          len2,
  input  logic [2:0]    kind,
  input  logic [AW-1:0] target,
  input  logic          cond_true,
  input  logic          take_tmr,
  input  logic          take_ext,
  input  logic          wake,
  input  logic          int_en,
  input  logic          carry_in,
  input  logic          page_f,
  output logic [AW-1:0] pc,
  output logic          halted,
  output logic          carry_restore,
  output logic          carry_restore_v,
  output logic [PW-1:0] tbl_page
);

  localparam logic [2:0] K_SEQ  = 3'd0;
  localparam logic [2:0] K_JMP  = 3'd1;
  localparam logic [2:0] K_CALL = 3'd2;
  localparam logic [2:0] K_COND = 3'd3;
  localparam logic [2:0] K_RET  = 3'd4;
  localparam logic [2:0] K_IRET = 3'd5;
  localparam logic [2:0] K_HALT = 3'd6;

  logic [AW-1:0] pc_q, pc_d, ret_q, ret_d;
  logic          rcf_q, rcf_d, halt_q, halt_d;

  wire irq  = !halt_q && (take_tmr || take_ext);
  wire exec = step && !halt_q && !irq;
  wire [AW-1:0] pc_p1 = pc_q + AW'(1);
  wire [AW-1:0] pc_p2 = pc_q + AW'(2);

  always_comb begin
    pc_d   = pc_q;
    ret_d  = ret_q;
    rcf_d  = rcf_q;
    halt_d = halt_q;
    if (halt_q) begin
      if (wake) begin
        halt_d = 1'b0;
        if (int_en) begin
          pc_d  = VEC_EXT;
          ret_d = pc_q;
          rcf_d = carry_in;
        end
      end
    end else if (irq) begin
      pc_d  = take_ext ? VEC_EXT : VEC_TMR;
      ret_d = pc_q;
      rcf_d = carry_in;
    end else if (step) begin
      case (kind)
        K_SEQ:  pc_d = len2 ? pc_p2 : pc_p1;
        K_JMP:  pc_d = target;
        K_CALL: begin pc_d = target; ret_d = pc_p2; end
        K_COND: pc_d = cond_true ? {pc_q[AW-1], target[AW-2:0]} : pc_p2;
        K_RET, K_IRET: pc_d = ret_q;
        K_HALT: begin pc_d = pc_p2; halt_d = 1'b1; end
        default: pc_d = len2 ? pc_p2 : pc_p1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      ret_q  <= '0;
      rcf_q  <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      ret_q  <= ret_d;
      rcf_q  <= rcf_d;
      halt_q <= halt_d;
    end
  end

  assign pc              = pc_q;
  assign halted          = halt_q;
  assign carry_restore   = rcf_q;
  assign carry_restore_v = exec && (kind == K_IRET);
  assign tbl_page        = page_f ? {PW{1'b1}} : pc_q[AW-1 -: PW];

  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    exec && kind == K_SEQ |=> pc == $past(pc) + (($past(len2)) ? AW'(2) : AW'(1))); // R2
  AST_COND_KEEPS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    exec && kind == K_COND && cond_true |=> pc[AW-1] == $past(pc[AW-1])); // R4
  AST_RETURN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    exec && (kind == K_RET || kind == K_IRET) |=> pc == $past(ret_q)); // R5
  AST_EXT_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    !halted && take_ext |=> pc == VEC_EXT); // R6
  AST_TMR_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    !halted && take_tmr && !take_ext |=> pc == VEC_TMR); // R6
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    halted && !wake |=> $stable(pc) && halted); // R9
  AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    halted && wake |=> !halted); // R10

endmodule

// File: tb/pc_seq_bench.sv
module pc_seq_bench;
  logic clk = 0, rst_n = 0;
  logic step = 0, len2 = 0, cond_true = 0, take_tmr = 0, take_ext = 0;
  logic wake = 0, int_en = 0, carry_in = 0, page_f = 0;
  logic [2:0] kind = 0;
  logic [11:0] target = 0;
  logic [11:0] pc;
  logic halted, carry_restore, carry_restore_v;
  logic [3:0] tbl_page;

  int checks = 0, fails = 0;
  int m_pc = 0, m_ret = 0, m_cf = 0, m_halt = 0;

  always #5 clk = ~clk;

  pc_seq u_pc_seq (.clk(clk), .rst_n(rst_n), .step(step), .len2(len2), .kind(kind),
    .target(target), .cond_true(cond_true), .take_tmr(take_tmr), .take_ext(take_ext),
    .wake(wake), .int_en(int_en), .carry_in(carry_in), .page_f(page_f), .pc(pc),
    .halted(halted), .carry_restore(carry_restore), .carry_restore_v(carry_restore_v),
    .tbl_page(tbl_page));

  task automatic cmp(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(string req, bit s, bit l2, int k, int tgt, bit c,
                     bit tt, bit te, bit wk, bit ie, bit cf, bit pf);
    int sv, exp_v, pg;
    step = s; len2 = l2; kind = 3'(k); target = 12'(tgt); cond_true = c;
    take_tmr = tt; take_ext = te; wake = wk; int_en = ie; carry_in = cf; page_f = pf;
    #1;
    exp_v = (!m_halt && !tt && !te && s && k == 5) ? 1 : 0;
    pg = pf ? 15 : (m_pc >> 8);
    cmp(req, "restore_v", carry_restore_v, exp_v);
    if (exp_v) cmp(req, "restore_cf", carry_restore, m_cf);
    cmp(req, "tbl_page", tbl_page, pg);
    @(posedge clk);
    if (m_halt) begin
      if (wk) begin
        m_halt = 0;
        if (ie) begin m_ret = m_pc; m_cf = cf; m_pc = 8; end
      end
    end else if (tt || te) begin
      m_ret = m_pc; m_cf = cf; m_pc = te ? 8 : 4;
    end else if (s) begin
      sv = m_pc;
      case (k)
        0: m_pc = (sv + (l2 ? 2 : 1)) % 4096;
        1: m_pc = tgt;
        2: begin m_ret = (sv + 2) % 4096; m_pc = tgt; end
        3: m_pc = c ? ((sv & 12'h800) | (tgt & 12'h7FF)) : (sv + 2) % 4096;
        4, 5: m_pc = m_ret;
        6: begin m_pc = (sv + 2) % 4096; m_halt = 1; end
        default: m_pc = (sv + (l2 ? 2 : 1)) % 4096;
      endcase
    end
    @(negedge clk);
    cmp(req, "pc", pc, m_pc);
    cmp(req, "halted", halted, m_halt);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    cmp("R1", "pc", pc, 0);
    cmp("R1", "halted", halted, 0);
    rst_n = 1;
    cyc("R2", 1,0,0,0,0, 0,0,0,0,0,0);
    cyc("R2", 1,1,0,0,0, 0,0,0,0,0,0);
    cyc("R2", 0,1,0,0,0, 0,0,0,0,0,0);
    cyc("R3", 1,1,1,12'hFFE,0, 0,0,0,0,0,0);
    cyc("R2", 1,1,0,0,0, 0,0,0,0,0,0);
    cyc("R3", 1,1,1,12'h9A0,0, 0,0,0,0,0,0);
    cyc("R4", 1,1,3,12'h123,1, 0,0,0,0,0,0);
    cyc("R4", 1,1,3,12'h777,0, 0,0,0,0,0,0);
    cyc("R4", 1,1,3,12'h7FF,1, 0,0,0,0,0,0);
    cyc("R4", 1,1,3,12'hFFF,1, 0,0,0,0,0,0);
    cyc("R3", 1,1,1,12'h200,0, 0,0,0,0,0,0);
    cyc("R5", 1,1,2,12'h450,0, 0,0,0,0,1,0);
    cyc("R5", 1,0,0,0,0, 0,0,0,0,1,0);
    cyc("R5", 1,0,4,0,0, 0,0,0,0,1,0);
    cyc("R6", 1,1,1,12'hABC,0, 1,0,0,1,1,0);
    cyc("R7", 1,0,0,0,0, 0,0,0,1,0,0);
    cyc("R7", 1,0,5,0,0, 0,0,0,1,0,0);
    cyc("R6", 1,0,0,0,0, 1,1,0,1,0,0);
    cyc("R8", 1,1,2,12'h5A0,0, 0,0,0,1,1,0);
    cyc("R8", 1,0,4,0,0, 0,0,0,1,1,0);
    cyc("R8", 1,0,5,0,0, 0,0,0,1,1,0);
    cyc("R6", 0,0,0,0,0, 0,1,0,1,1,0);
    cyc("R7", 1,0,5,0,0, 0,0,0,1,0,0);
    cyc("R3", 1,1,1,12'h300,0, 0,0,0,0,0,0);
    cyc("R9", 1,1,6,0,0, 0,0,0,0,0,0);
    cyc("R9", 1,1,1,12'h111,0, 0,0,0,0,0,0);
    cyc("R9", 0,0,0,0,0, 1,1,0,0,0,0);
    cyc("R10", 0,0,0,0,0, 0,0,1,0,0,0);
    cyc("R9", 1,1,6,0,0, 0,0,0,1,0,0);
    cyc("R10", 0,0,0,0,0, 0,0,1,1,1,0);
    cyc("R10", 1,0,5,0,0, 0,0,0,1,0,0);
    cyc("R3", 1,1,1,12'h5C3,0, 0,0,0,0,0,0);
    cyc("R11", 0,0,0,0,0, 0,0,0,0,0,0);
    cyc("R11", 0,0,0,0,0, 0,0,0,0,0,1);
    for (int i = 0; i < 20; i++)
      cyc("R2", 1,i[0],0,0,0, 0,0,0,0,0,i[1]);
    rst_n = 0; #1;
    cmp("R1", "pc", pc, 0);
    cmp("R1", "halted", halted, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule